// File: doc/BRIEF.md
# Disk Transfer Function and Status Controller

This block decides what a disk channel does with each word slot as it passes the heads. Software writes a three-bit function word into a staging register. The two low bits select the operation: none, read, write, or write-check. The top bit enables the interrupt. A separate execute command copies the operation code into a running register, and the transfer then proceeds. During a read, each matched slot places the assembled disk word in a shared buffer and requests the channel. During a write or a write-check, the channel fills the same buffer first, and the word is then consumed at the next matched slot, either handed on to the serializer or compared against what the disk returned.

Every terminating condition clears only the running register and raises the disk flag. These conditions are completion, a parity fault, a check mismatch and a protected-write attempt. The staging register keeps its value, so one execute command resumes the transfer or starts a new one. Of the three data errors, only the first one is recorded until software clears the status. Two conditions only leave a warning bit and do not stop the transfer: a channel that falls behind, and a command that makes no sense.

Top module: `dxc_xfer_ctrl`

## Requirements
- R1: After reset, `status`, `fn_armed`, `fn_running`, `req`, `buf_q`, `shift_load`, `disk_flag` and `irq` are all zero.
- R2: When `fn_running` is 00, `sw_load` copies `sw_fn` into `fn_armed` on the next edge. The field layout is: bit 2 is the interrupt enable; bits 1:0 are the operation, with 00 none, 01 read, 10 write and 11 write-check.
- R3: `sw_exec` with `fn_running` 00 and `fn_armed[1:0]` nonzero copies `fn_armed[1:0]` into `fn_running` on the next edge. Starting a write or a write-check raises `req` at that edge; starting a read leaves `req` low. If `sw_load` and `sw_exec` arrive in the same cycle, the execute uses the earlier staged value.
- R4: A terminating event clears `fn_running` on the same edge that sets its status bit. The terminating events are status bits 0 to 3. `fn_armed` is kept, and a later `sw_exec` restarts the same operation.
- R5: A slot is a cycle with both `addr_hit` and `word_strobe` high; `word_strobe` alone does nothing. In read mode a slot loads `disk_word` into `buf_q` and raises `req`. `chan_ack` while `req` is high drops `req`. If `last_word` is high with that acknowledge, status bit 0 (done) is set.
- R6: In write mode, `chan_ack` while `req` is high loads `chan_wdata` into `buf_q` and drops `req`. The next slot consumes the word: `shift_load` pulses for one cycle after that slot edge, with `buf_q` still holding the word. `req` rises again unless the word arrived with `last_word`; in that case status bit 0 is set instead.
- R7: In write-check mode, a slot that consumes a word compares `buf_q` with `disk_word`. A difference sets status bit 2 and stops the transfer. In read or write-check mode, `parity_err` at a slot sets status bit 1 and stops the transfer; it takes precedence over a mismatch in the same slot. In read mode the word is still captured and `req` stays high.
- R8: In write mode, a slot with `protect` high sets status bit 3, drops `req`, consumes nothing and stops the transfer. In read and write-check modes, `protect` has no effect.
- R9: Of status bits 1, 2 and 3, at most one is ever set. Once one is set, the others stay clear until `sw_clear`, even across restarts.
- R10: Status bit 4 (late) is set in two cases: a read slot while `req` is still high with no `chan_ack` in that cycle, or a write or write-check slot with no word held. It does not raise the flag and does not stop the transfer.
- R11: `sw_load` or `sw_exec` while `fn_running` is nonzero, or `sw_exec` with `fn_armed[1:0]` equal to 00, is ignored and sets status bit 5 (command error). This bit does not raise the flag.
- R12: `disk_flag` is the OR of status bits 0 to 3, and `irq` is `disk_flag` ANDed with `fn_armed[2]`. `sw_clear` zeroes all of `status`, and it wins over any set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_load | input | 1 | Stage `sw_fn` into the function register |
| sw_exec | input | 1 | Execute the staged function |
| sw_clear | input | 1 | Clear all status bits |
| sw_fn | input | 3 | Function word: {irq enable, operation[1:0]} |
| addr_hit | input | 1 | Current slot address matches the target |
| word_strobe | input | 1 | Word assembled / slot boundary |
| disk_word | input | W | Word read from the disk at this slot |
| parity_err | input | 1 | Parity fault on the word at this slot |
| protect | input | 1 | Current slot lies in a write-protected region |
| chan_ack | input | 1 | Channel has served the request |
| last_word | input | 1 | This acknowledge carries the final word |
| chan_wdata | input | W | Memory word supplied by the channel |
| req | output | 1 | Word ready (read) or word needed (write, check) |
| buf_q | output | W | Shared buffer register |
| shift_load | output | 1 | One-cycle pulse: buffer handed to serializer |
| status | output | 6 | {cmd, late, lock, mismatch, parity, done} |
| fn_armed | output | 3 | Staged function word |
| fn_running | output | 2 | Executing operation code |
| disk_flag | output | 1 | Done or data error pending |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 12-bit word. This keeps random data readable while every compare bit still comes from a generated XOR lane. Random words exercise capture and comparison. Stray strobes without an address hit confirm that only true slots act. Directed sequences reach the awkward cases: a parity fault with a word pending, a restart after a stop, a second data error that must be suppressed, and a protected slot seen in write and in write-check mode.

// File: rtl/dxc_pkg.sv
package dxc_pkg;

    typedef enum logic [1:0] {
        FN_IDLE  = 2'b00,
        FN_READ  = 2'b01,
        FN_WRITE = 2'b10,
        FN_CHECK = 2'b11
    } fn_code_e;

    typedef struct packed {
        logic     ie;
        fn_code_e code;
    } fn_word_t;

    // status / event layout, bit 0 first from the right
    typedef struct packed {
        logic cmd;
        logic late;
        logic lock;
        logic mismatch;
        logic parity;
        logic done;
    } ev_t;

    localparam int ST_BITS = $bits(ev_t);

    function automatic logic is_stop(input ev_t e);
        return e.done | e.parity | e.mismatch | e.lock;
    endfunction

    function automatic logic any_data_err(input ev_t e);
        return e.parity | e.mismatch | e.lock;
    endfunction

endpackage

// File: rtl/dxc_fn_regs.sv
module dxc_fn_regs
    import dxc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ld,
    input  logic     ex,
    input  fn_word_t wdata,
    input  logic     term,
    output fn_word_t armed,
    output fn_code_e running,
    output logic     start,
    output logic     cmd_bad
);
    logic busy;

    always_comb begin
        busy    = (running != FN_IDLE);
        start   = ex && !busy && (armed.code != FN_IDLE);
        cmd_bad = ((ld || ex) && busy) || (ex && !busy && (armed.code == FN_IDLE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= '0;
            running <= FN_IDLE;
        end else begin
            if (ld && !busy)
                armed <= wdata;
            if (term)
                running <= FN_IDLE;
            else if (start)
                running <= armed.code;
        end
    end

    // R3: execution only begins on an execute command
    p_exec_needs_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        (running != FN_IDLE && $past(running) == FN_IDLE) |-> $past(ex));

    // R11: staged function cannot change while running
    p_armed_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (running != FN_IDLE) |=> $stable(armed));

endmodule

// File: rtl/dxc_xfer_seq.sv
module dxc_xfer_seq
    import dxc_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  fn_code_e     running,
    input  logic         start,
    input  fn_code_e     start_code,
    input  logic         addr_hit,
    input  logic         word_strobe,
    input  logic [W-1:0] disk_word,
    input  logic         parity_err,
    input  logic         protect,
    input  logic         chan_ack,
    input  logic         last_word,
    input  logic [W-1:0] chan_wdata,
    output logic         req,
    output logic [W-1:0] buf_q,
    output logic         shift_load,
    output ev_t          ev
);
    logic         full;
    logic         last_held;
    logic         rd_mode;
    logic [W-1:0] diff;
    logic         mismatch;
    logic         slot, is_rd, is_wr, is_ck, consume, served;

    // per-bit comparison lanes for write-check
    for (genvar i = 0; i < W; i++) begin : g_cmp
        assign diff[i] = buf_q[i] ^ disk_word[i];
    end
    assign mismatch = |diff;

    always_comb begin
        slot    = addr_hit && word_strobe;
        is_rd   = (running == FN_READ);
        is_wr   = (running == FN_WRITE);
        is_ck   = (running == FN_CHECK);
        served  = chan_ack && req;
        consume = (is_wr || is_ck) && slot && full && !(is_wr && protect);
        ev      = '0;
        if (is_rd) begin
            if (served && last_word)
                ev.done = 1'b1;
            if (slot) begin
                if (req && !chan_ack)
                    ev.late = 1'b1;
                if (parity_err)
                    ev.parity = 1'b1;
            end
        end else if ((is_wr || is_ck) && slot) begin
            if (is_wr && protect)
                ev.lock = 1'b1;
            else if (!full)
                ev.late = 1'b1;
            else if (is_ck && parity_err)
                ev.parity = 1'b1;
            else if (is_ck && mismatch)
                ev.mismatch = 1'b1;
            else if (last_held)
                ev.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req        <= 1'b0;
            full       <= 1'b0;
            last_held  <= 1'b0;
            rd_mode    <= 1'b0;
            buf_q      <= '0;
            shift_load <= 1'b0;
        end else begin
            shift_load <= consume && is_wr;
            if (start) begin
                req       <= (start_code != FN_READ);
                rd_mode   <= (start_code == FN_READ);
                full      <= 1'b0;
                last_held <= 1'b0;
            end else begin
                if (served) begin
                    req <= 1'b0;
                    if (!rd_mode) begin
                        buf_q     <= chan_wdata;
                        full      <= 1'b1;
                        last_held <= last_word;
                    end
                end
                if (is_rd && slot) begin
                    buf_q <= disk_word;
                    req   <= 1'b1;
                end
                if (consume) begin
                    full <= 1'b0;
                    req  <= !last_held;
                end
                if (is_stop(ev) && !is_rd)
                    req <= 1'b0;
            end
        end
    end

    // R6: never ask for a word while one is still held
    p_no_need_when_full_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_mode |-> !(req && full));

    // R6: serializer hand-off only follows a write-mode slot
    p_shift_write_r6: assert property (@(posedge clk) disable iff (rst)
        shift_load |-> ($past(running) == FN_WRITE && $past(slot)));

    // R8: a protected write slot never hands a word on
    p_lock_no_shift_r8: assert property (@(posedge clk) disable iff (rst)
        (is_wr && slot && protect) |=> !shift_load);

endmodule

// File: rtl/dxc_status.sv
module dxc_status
    import dxc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ev_t  ev,
    input  logic clr,
    input  logic ie,
    output ev_t  st,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st <= '0;
        end else begin
            if (ev.done) st.done <= 1'b1;
            if (ev.late) st.late <= 1'b1;
            if (ev.cmd)  st.cmd  <= 1'b1;
            if (!any_data_err(st)) begin
                if (ev.parity)        st.parity   <= 1'b1;
                else if (ev.mismatch) st.mismatch <= 1'b1;
                else if (ev.lock)     st.lock     <= 1'b1;
            end
        end
    end

    always_comb begin
        flag = is_stop(st);
        irq  = flag && ie;
    end

    // R9: data errors are mutually exclusive
    p_one_error_r9: assert property (@(posedge clk) disable iff (rst)
        $countones({st.parity, st.mismatch, st.lock}) <= 1);

    // R10/R11: warnings alone never raise the flag
    p_warn_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        ((ev.late || ev.cmd) && !is_stop(ev) && !flag) |=> !flag);

    // R12: clear drops everything
    p_clear_r12: assert property (@(posedge clk) disable iff (rst)
        clr |=> (st == '0));

endmodule

// File: rtl/dxc_xfer_ctrl.sv
module dxc_xfer_ctrl
    import dxc_pkg::*;
#(
    parameter int W = 18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_load,
    input  logic               sw_exec,
    input  logic               sw_clear,
    input  logic [2:0]         sw_fn,
    input  logic               addr_hit,
    input  logic               word_strobe,
    input  logic [W-1:0]       disk_word,
    input  logic               parity_err,
    input  logic               protect,
    input  logic               chan_ack,
    input  logic               last_word,
    input  logic [W-1:0]       chan_wdata,
    output logic               req,
    output logic [W-1:0]       buf_q,
    output logic               shift_load,
    output logic [ST_BITS-1:0] status,
    output logic [2:0]         fn_armed,
    output logic [1:0]         fn_running,
    output logic               disk_flag,
    output logic               irq
);
    fn_word_t armed;
    fn_code_e running;
    logic     start, cmd_bad, term;
    ev_t      ev_seq, ev_all, st;

    dxc_fn_regs u_fn (
        .clk     (clk),
        .rst     (rst),
        .ld      (sw_load),
        .ex      (sw_exec),
        .wdata   (fn_word_t'(sw_fn)),
        .term    (term),
        .armed   (armed),
        .running (running),
        .start   (start),
        .cmd_bad (cmd_bad)
    );

    dxc_xfer_seq #(.W(W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .running     (running),
        .start       (start),
        .start_code  (armed.code),
        .addr_hit    (addr_hit),
        .word_strobe (word_strobe),
        .disk_word   (disk_word),
        .parity_err  (parity_err),
        .protect     (protect),
        .chan_ack    (chan_ack),
        .last_word   (last_word),
        .chan_wdata  (chan_wdata),
        .req         (req),
        .buf_q       (buf_q),
        .shift_load  (shift_load),
        .ev          (ev_seq)
    );

    always_comb begin
        term       = is_stop(ev_seq);
        ev_all     = ev_seq;
        ev_all.cmd = cmd_bad;
    end

    dxc_status u_st (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev_all),
        .clr  (sw_clear),
        .ie   (armed.ie),
        .st   (st),
        .flag (disk_flag),
        .irq  (irq)
    );

    assign status     = st;
    assign fn_armed   = armed;
    assign fn_running = running;

    // R4: whenever the flag goes up the operation has already stopped
    p_flag_stops_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(disk_flag) |-> (fn_running == 2'b00));

    // R4: termination leaves the staged function alone
    p_term_keeps_armed_r4: assert property (@(posedge clk) disable iff (rst)
        (term && !sw_load) |=> $stable(fn_armed));

endmodule

// File: tb/dxc_xfer_ctrl_test.sv
module dxc_xfer_ctrl_test;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sw_load = 0, sw_exec = 0, sw_clear = 0;
    logic [2:0]    sw_fn = '0;
    logic          addr_hit = 0, word_strobe = 0, parity_err = 0, protect = 0;
    logic          chan_ack = 0, last_word = 0;
    logic [DW-1:0] disk_word = '0, chan_wdata = '0;
    logic          req, shift_load, disk_flag, irq;
    logic [DW-1:0] buf_q;
    logic [5:0]    status;
    logic [2:0]    fn_armed;
    logic [1:0]    fn_running;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    dxc_xfer_ctrl #(.W(DW)) uut (
        .clk(clk), .rst(rst), .sw_load(sw_load), .sw_exec(sw_exec), .sw_clear(sw_clear),
        .sw_fn(sw_fn), .addr_hit(addr_hit), .word_strobe(word_strobe), .disk_word(disk_word),
        .parity_err(parity_err), .protect(protect), .chan_ack(chan_ack), .last_word(last_word),
        .chan_wdata(chan_wdata), .req(req), .buf_q(buf_q), .shift_load(shift_load),
        .status(status), .fn_armed(fn_armed), .fn_running(fn_running),
        .disk_flag(disk_flag), .irq(irq)
    );

    // status bit weights
    localparam logic [5:0] S_DONE = 6'd1, S_PAR = 6'd2, S_MIS = 6'd4,
                           S_LOCK = 6'd8, S_LATE = 6'd16, S_CMD = 6'd32;

    function automatic logic [DW-1:0] rnd_word();
        return DW'($urandom());
    endfunction

    function automatic logic flag_of(input logic [5:0] s);
        return |s[3:0];
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [2:0] f);
        sw_load = 1; sw_fn = f; tick(); sw_load = 0;
    endtask

    task automatic do_exec();
        sw_exec = 1; tick(); sw_exec = 0;
    endtask

    task automatic do_clear();
        sw_clear = 1; tick(); sw_clear = 0;
    endtask

    task automatic do_slot(input logic [DW-1:0] w, input logic par, input logic prot);
        addr_hit = 1; word_strobe = 1; disk_word = w; parity_err = par; protect = prot;
        tick();
        addr_hit = 0; word_strobe = 0; parity_err = 0; protect = 0;
    endtask

    task automatic do_ack(input logic [DW-1:0] d, input logic last);
        chan_ack = 1; chan_wdata = d; last_word = last;
        tick();
        chan_ack = 0; last_word = 0;
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        logic [DW-1:0] w, d, held;
        void'($urandom(32'd1987));
        repeat (3) tick();
        rst = 0;
        tick();

        // R1 reset state
        chk("R1 status", 32'(status), 0);
        chk("R1 armed/running", 32'({fn_armed, fn_running}), 0);
        chk("R1 req/flag/irq/shift", 32'({req, disk_flag, irq, shift_load}), 0);
        chk("R1 buf", 32'(buf_q), 0);

        // R11 execute with nothing staged
        do_exec();
        chk("R11 exec nop status", 32'(status), 32'(S_CMD));
        chk("R11 exec nop running", 32'(fn_running), 0);
        chk("R11 no flag", 32'(disk_flag), 0);
        do_clear();
        chk("R12 clear", 32'(status), 0);

        // R2/R3/R5 random read run with stray strobes
        do_load(3'b101);
        chk("R2 armed", 32'(fn_armed), 32'h5);
        do_exec();
        chk("R3 running read", 32'(fn_running), 1);
        chk("R3 read req low", 32'(req), 0);
        held = buf_q;
        for (int k = 0; k < 16; k++) begin
            if ($urandom_range(0, 1) == 1) begin
                word_strobe = 1; disk_word = rnd_word(); tick(); word_strobe = 0;
                chk("R5 strobe alone ignored", 32'({req, buf_q}), 32'({1'b0, held}));
            end
            w = rnd_word();
            do_slot(w, 0, $urandom_range(0, 1) == 1);
            chk("R5 read capture", 32'({req, buf_q}), 32'({1'b1, w}));
            held = w;
            do_ack(rnd_word(), k == 15);
            chk("R5 ack drops req", 32'(req), 0);
            if (k != 15) chk("R8 protect ignored in read", 32'(status), 0);
        end
        chk("R5 done status", 32'(status), 32'(S_DONE));
        chk("R4 stopped, armed kept", 32'({fn_running, fn_armed}), 32'({2'b00, 3'b101}));
        chk("R12 flag+irq", 32'({disk_flag, irq}), 32'b11);
        do_clear();
        chk("R12 clear drops irq", 32'({disk_flag, irq}), 0);

        // R11 commands while busy
        do_exec();
        chk("R4 restart", 32'(fn_running), 1);
        do_load(3'b010);
        chk("R11 load ignored", 32'({fn_armed, status}), 32'({3'b101, S_CMD}));
        do_exec();
        chk("R11 exec ignored", 32'({fn_running, status}), 32'({2'b01, S_CMD}));
        do_clear();

        // R10 read late, R7 parity in read
        do_slot(rnd_word(), 0, 0);
        w = rnd_word();
        do_slot(w, 0, 0);
        chk("R10 read late", 32'({status, disk_flag, fn_running}), 32'({S_LATE, 1'b0, 2'b01}));
        chk("R10 buf overwritten", 32'(buf_q), 32'(w));
        w = rnd_word();
        do_slot(w, 1, 0);
        chk("R7 read parity", 32'(status), 32'(S_LATE | S_PAR));
        chk("R7 stop keeps req", 32'({fn_running, req, disk_flag, buf_q}), 32'({2'b00, 1'b1, 1'b1, w}));
        do_ack(rnd_word(), 1);
        chk("R7 ack after stop", 32'({req, status}), 32'({1'b0, S_LATE | S_PAR}));
        do_exec();
        chk("R4 resume read", 32'({fn_running, fn_armed}), 32'({2'b01, 3'b101}));
        do_slot(rnd_word(), 0, 0);
        do_ack(rnd_word(), 1);
        chk("R5 done after resume", 32'(status), 32'(S_LATE | S_PAR | S_DONE));
        do_clear();

        // R6/R10 write, no interrupt enable
        do_load(3'b010);
        do_exec();
        chk("R3 write req", 32'({fn_running, req}), 32'({2'b10, 1'b1}));
        do_slot(rnd_word(), 0, 0);
        chk("R10 write late", 32'({status, disk_flag, fn_running}), 32'({S_LATE, 1'b0, 2'b10}));
        do_clear();
        d = rnd_word();
        do_ack(d, 0);
        chk("R6 ack loads", 32'({req, buf_q}), 32'({1'b0, d}));
        do_slot(rnd_word(), 0, 0);
        chk("R6 shift pulse", 32'({shift_load, buf_q, req}), 32'({1'b1, d, 1'b1}));
        tick();
        chk("R6 pulse one cycle", 32'(shift_load), 0);
        d = rnd_word();
        do_ack(d, 1);
        do_slot(rnd_word(), 0, 0);
        chk("R6 last word", 32'({shift_load, buf_q, req}), 32'({1'b1, d, 1'b0}));
        chk("R6 write done", 32'({status, fn_running}), 32'({S_DONE, 2'b00}));
        chk("R12 flag no irq", 32'({disk_flag, irq}), 32'b10);
        do_clear();

        // R8 protected write
        do_exec();
        do_ack(rnd_word(), 0);
        do_slot(rnd_word(), 0, 1);
        chk("R8 lockout", 32'({status, fn_running, req, shift_load}), 32'({S_LOCK, 2'b00, 1'b0, 1'b0}));
        do_clear();

        // R7/R8 write-check run, protect ignored
        do_load(3'b011);
        do_exec();
        for (int k = 0; k < 8; k++) begin
            d = rnd_word();
            do_ack(d, k == 7);
            do_slot(d, 0, $urandom_range(0, 1) == 1);
            chk("R7 check match", 32'({req, shift_load}), 32'({k != 7, 1'b0}));
        end
        chk("R8 check done no lock", 32'(status), 32'(S_DONE));
        do_clear();

        // R9 first error only; R7 parity beats mismatch
        do_exec();
        d = rnd_word();
        do_ack(d, 0);
        do_slot(d ^ DW'(1), 1, 0);
        chk("R7 parity over mismatch", 32'({status, fn_running}), 32'({S_PAR, 2'b00}));
        do_exec();
        d = rnd_word();
        do_ack(d, 0);
        do_slot(d ^ DW'(2), 0, 0);
        chk("R9 second error suppressed", 32'({status, fn_running, req}), 32'({S_PAR, 2'b00, 1'b0}));
        do_clear();
        do_exec();
        d = rnd_word();
        do_ack(d, 0);
        do_slot(d ^ DW'(4), 0, 0);
        chk("R7 mismatch", 32'({status, fn_running, flag_of(status)}), 32'({S_MIS, 2'b00, 1'b1}));

        // R12 clear wins over a same-cycle set
        do_exec();
        sw_clear = 1; addr_hit = 1; word_strobe = 1; tick();
        sw_clear = 0; addr_hit = 0; word_strobe = 0;
        chk("R12 clear wins", 32'(status), 0);

        finished = 1;
        report();
    end
endmodule